// File: doc/BRIEF.md
# SMBus Monitor Register Target

This block is the serial-bus face of a power-monitor sensor. It is an SMBus/I2C-compatible target with two registers behind one-byte command codes. The first is a 16-bit configuration word that the host can both write and read. The second is a read-only measurement word supplied by a neighbouring measurement block. Three different read command codes (0x8B, 0x8C and 0x96) all return that one measurement word, so host software may use whichever code suits it.

The 7-bit bus address comes from a strap pin that can take three levels. Writes are word writes: address, command, low byte, high byte. Reads use the same address and command phase, then a repeated start, then two bytes returned low byte first. When the host finishes reading the measurement word, the block raises a one-cycle strobe. The measurement block uses that strobe to release a pending alert. SCL and SDA are sampled on a fast system clock, at least eight times the SCL rate. The block drives SDA open-drain and never touches SCL.

Top module: `smb_mon_target`

## Requirements
- R1: The strap input selects the address: code 00 (low) selects 0x70, 01 (open) selects 0x72, 10 (high) selects 0x76, and code 11 matches no address. A matching address byte with the write bit (bit 0 = 0) is acknowledged.
- R2: An address byte that does not match is not acknowledged. SDA is then never pulled low again until the next start condition, and no register changes.
- R3: After reset the configuration word is 0x0000. A write of command 0xD0 with low byte L then high byte H sets it to {H,L}.
- R4: The configuration word changes only after both data bytes of a write have been received and acknowledged. A stop that follows only one data byte leaves the word unchanged.
- R5: A read of command 0xD0 (command write, repeated start, address with bit 0 = 1) returns the configuration word, low byte first.
- R6: Reads of commands 0x8B, 0x8C and 0x96 each return the current measurement input word, low byte first.
- R7: Any other command code, including the reserved codes 0xD2 to 0xD5, 0xD7 and 0xD8, is acknowledged. A read of such a code returns 0xFFFF, and a write to it leaves the configuration word unchanged. A write to a measurement code also leaves the configuration word unchanged.
- R8: `data_taken` pulses for exactly one clock cycle each time the host clocks the acknowledge slot after the high byte of a measurement-code read. It does not pulse for configuration reads.
- R9: The target changes its SDA drive only while SCL is low. It releases SDA for the master's acknowledge slot, after a stop, and at every start.
- R10: A data byte that arrives after the two data bytes of a write is not acknowledged, and it does not alter the word already committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| addr_strap | input | 2 | Address strap level: 00 low, 01 open, 10 high, 11 invalid |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired value) |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| meas_word | input | 16 | Measurement word from the sensing block |
| cfg_word | output | 16 | Current configuration word |
| data_taken | output | 1 | One-cycle strobe when a measurement read completes |

## Verification
The hardest situations to reach from the pins are the ones where the host cuts a transfer short or runs it long. One case is a stop after a single data byte. Another is a third data byte after a committed write. A third is a read whose command was written earlier in the same transaction, before the repeated start. The bench reaches these through a bit-level bus master whose write task takes the number of data bytes to send. It then compares the configuration port against a value that only a correct commit point would produce. A mismatched address is also sent with its full payload, so that a stray acknowledge anywhere in the ignored bytes is seen on the wired SDA line.

// File: rtl/smb_mon_pkg.sv
package smb_mon_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    localparam logic [7:0] CMD_CFG   = 8'hD0;
    localparam logic [7:0] CMD_OUT_A = 8'h8B;
    localparam logic [7:0] CMD_OUT_B = 8'h8C;
    localparam logic [7:0] CMD_OUT_C = 8'h96;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_END,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_END,
        ST_CMD_ACK,
        ST_WR,
        ST_WR_END,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } smb_st_e;

    typedef struct packed {
        logic              ok;
        logic [6:0]        addr;
    } strap_addr_t;

    function automatic strap_addr_t decode_strap(input logic [1:0] lvl);
        strap_addr_t r;
        r.ok = 1'b1;
        case (lvl)
            2'b00:   r.addr = 7'h70;
            2'b01:   r.addr = 7'h72;
            2'b10:   r.addr = 7'h76;
            default: begin r.ok = 1'b0; r.addr = 7'h00; end
        endcase
        return r;
    endfunction

    function automatic logic is_out_cmd(input logic [7:0] c);
        return (c == CMD_OUT_A) || (c == CMD_OUT_B) || (c == CMD_OUT_C);
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '1;
            prev <= 1'b1;
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
            prev <= pipe[STAGES-1];
        end
    end

    assign lvl  = pipe[STAGES-1];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/smb_proto.sv
module smb_proto
    import smb_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  strap_addr_t       own,
    input  logic [WORD_W-1:0] rd_word,
    output logic              sda_low,
    output logic [7:0]        cmd,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic              rd_hi_done
);
    smb_st_e           st;
    logic [2:0]        bitcnt;
    logic [7:0]        sh;
    logic [7:0]        tx;
    logic [7:0]        lo_b;
    logic [WORD_W-1:0] snap;
    logic              rw;
    logic              hi;
    logic              mack;

    wire ev_start = sda_fall & scl_lvl;
    wire ev_stop  = sda_rise & scl_lvl;

    always_ff @(posedge clk) begin
        wr_en      <= 1'b0;
        rd_hi_done <= 1'b0;
        if (rst) begin
            st      <= ST_IDLE;
            sda_low <= 1'b0;
            bitcnt  <= '0;
            sh      <= '0;
            tx      <= '0;
            lo_b    <= '0;
            snap    <= '0;
            rw      <= 1'b0;
            hi      <= 1'b0;
            mack    <= 1'b0;
            cmd     <= '0;
            wr_data <= '0;
        end else if (ev_stop) begin
            st      <= ST_IDLE;
            sda_low <= 1'b0;
        end else if (ev_start) begin
            st      <= ST_ADDR;
            sda_low <= 1'b0;
            bitcnt  <= '0;
        end else begin
            case (st)
                ST_ADDR, ST_CMD, ST_WR: if (scl_rise) begin
                    sh     <= {sh[6:0], sda_lvl};
                    bitcnt <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7)
                        st <= (st == ST_ADDR) ? ST_ADDR_END :
                              (st == ST_CMD)  ? ST_CMD_END  : ST_WR_END;
                end
                ST_ADDR_END: if (scl_fall) begin
                    if (own.ok && sh[7:1] == own.addr) begin
                        sda_low <= 1'b1;
                        rw      <= sh[0];
                        st      <= ST_ADDR_ACK;
                    end else begin
                        st <= ST_SKIP;
                    end
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    bitcnt <= '0;
                    hi     <= 1'b0;
                    if (rw) begin
                        snap    <= rd_word;
                        tx      <= rd_word[7:0];
                        sda_low <= ~rd_word[7];
                        st      <= ST_RD;
                    end else begin
                        sda_low <= 1'b0;
                        st      <= ST_CMD;
                    end
                end
                ST_CMD_END: if (scl_fall) begin
                    cmd     <= sh;
                    sda_low <= 1'b1;
                    st      <= ST_CMD_ACK;
                end
                ST_CMD_ACK: if (scl_fall) begin
                    sda_low <= 1'b0;
                    bitcnt  <= '0;
                    hi      <= 1'b0;
                    st      <= ST_WR;
                end
                ST_WR_END: if (scl_fall) begin
                    sda_low <= 1'b1;
                    if (!hi) lo_b <= sh;
                    st <= ST_WR_ACK;
                end
                ST_WR_ACK: if (scl_fall) begin
                    sda_low <= 1'b0;
                    bitcnt  <= '0;
                    if (!hi) begin
                        hi <= 1'b1;
                        st <= ST_WR;
                    end else begin
                        wr_en   <= 1'b1;
                        wr_data <= {sh, lo_b};
                        st      <= ST_SKIP;
                    end
                end
                ST_RD: if (scl_fall) begin
                    if (bitcnt == 3'd7) begin
                        sda_low <= 1'b0;
                        st      <= ST_RD_ACK;
                    end else begin
                        tx      <= {tx[6:0], 1'b0};
                        sda_low <= ~tx[6];
                        bitcnt  <= bitcnt + 3'd1;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_lvl;
                        if (hi) rd_hi_done <= 1'b1;
                    end
                    if (scl_fall) begin
                        if (mack && !hi) begin
                            hi      <= 1'b1;
                            tx      <= snap[15:8];
                            sda_low <= ~snap[15];
                            bitcnt  <= '0;
                            st      <= ST_RD;
                        end else begin
                            st <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R9: drive changes follow an SCL fall, or a start/stop release
    a_r9_sda_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_low) |-> $past(scl_fall || ev_start || ev_stop));

    // R2: ignored or idle bus is never pulled
    a_r2_quiet_when_skipping: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SKIP || st == ST_IDLE) |-> !sda_low);
endmodule

// File: rtl/smb_regs.sv
module smb_regs
    import smb_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        cmd,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_hi_done,
    input  logic [WORD_W-1:0] meas_word,
    output logic [WORD_W-1:0] cfg_q,
    output logic [WORD_W-1:0] rd_word,
    output logic              data_taken
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            data_taken <= 1'b0;
        end else begin
            if (wr_en && cmd == CMD_CFG) cfg_q <= wr_data;
            data_taken <= rd_hi_done && is_out_cmd(cmd);
        end
    end

    always_comb begin
        if (cmd == CMD_CFG)      rd_word = cfg_q;
        else if (is_out_cmd(cmd)) rd_word = meas_word;
        else                      rd_word = '1;
    end

    // R4: configuration only moves on a committed configuration write
    a_r4_cfg_on_commit: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_q) |-> $past(wr_en && cmd == CMD_CFG));

    // R8: strobe is a single cycle wide
    a_r8_taken_single: assert property (@(posedge clk) disable iff (rst)
        data_taken |=> !data_taken);
endmodule

// File: rtl/smb_mon_target.sv
module smb_mon_target
    import smb_mon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        addr_strap,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull,
    input  logic [WORD_W-1:0] meas_word,
    output logic [WORD_W-1:0] cfg_word,
    output logic              data_taken
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw, lvl, rise, fall;
    logic [7:0]         cmd;
    logic               wr_en, rd_hi_done;
    logic [WORD_W-1:0]  wr_data, rd_word;
    strap_addr_t        own;

    assign raw = {sda_i, scl_i};
    assign own = decode_strap(addr_strap);

    for (genvar i = 0; i < N_LINES; i++) begin : g_sync
        smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw[i]),
            .lvl  (lvl[i]),
            .rise (rise[i]),
            .fall (fall[i])
        );
    end

    smb_proto u_proto (
        .clk        (clk),
        .rst        (rst),
        .scl_lvl    (lvl[0]),
        .scl_rise   (rise[0]),
        .scl_fall   (fall[0]),
        .sda_lvl    (lvl[1]),
        .sda_rise   (rise[1]),
        .sda_fall   (fall[1]),
        .own        (own),
        .rd_word    (rd_word),
        .sda_low    (sda_pull),
        .cmd        (cmd),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_hi_done (rd_hi_done)
    );

    smb_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_hi_done (rd_hi_done),
        .meas_word  (meas_word),
        .cfg_q      (cfg_word),
        .rd_word    (rd_word),
        .data_taken (data_taken)
    );
endmodule

// File: tb/sim_smb_mon_target.sv
module sim_smb_mon_target;
    localparam int Q = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  strap = 2'b00;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_pull;
    logic [15:0] meas = 16'h1380;
    logic [15:0] cfg;
    logic        taken;
    wire         sda_bus = sda_m & ~sda_pull;

    always #5 clk = ~clk;

    smb_mon_target u0 (
        .clk(clk), .rst(rst), .addr_strap(strap), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_pull(sda_pull), .meas_word(meas), .cfg_word(cfg), .data_taken(taken)
    );

    typedef struct { int req; logic [31:0] val; } item_t;
    item_t exp_q[$];
    item_t act_q[$];
    int checks = 0, fails = 0;
    int taken_cnt = 0, bad_moves = 0, pull_cnt = 0;
    logic prev_pull = 1'b0, prev_scl = 1'b1;

    // wired-bus monitor, sampled clear of the clock edge
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            if (taken) taken_cnt++;
            if (sda_pull) pull_cnt++;
            if (sda_pull != prev_pull && scl_m && prev_scl) bad_moves++;
        end
        prev_pull = sda_pull;
        prev_scl  = scl_m;
    end

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pairs observed bus results with expectations
    initial forever begin
        @(negedge clk);
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            item_t e, a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            check(e.req, a.val, e.val);
        end
    end

    task automatic expect_item(input int req, input logic [31:0] v);
        item_t it;
        it.req = req; it.val = v;
        exp_q.push_back(it);
    endtask

    task automatic observe(input logic [31:0] v);
        item_t it;
        it.req = 0; it.val = v;
        act_q.push_back(it);
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(); scl_m = 1'b1; hold();
        sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(); scl_m = 1'b1; hold(); sda_m = 1'b1; hold();
    endtask

    task automatic bit_io(input logic v, output logic s);
        sda_m = v; hold(); scl_m = 1'b1; hold();
        s = sda_bus; hold(); scl_m = 1'b0; hold();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); b[i] = s; end
        bit_io(~give_ack, s);
        sda_m = 1'b1;
    endtask

    // pushes {addr ack, cmd ack, data acks} then nothing else
    task automatic wr_txn(input logic [6:0] a, input logic [7:0] c,
                          input logic [15:0] w, input int nbytes);
        logic k0, k1, k2, k3, k4;
        k2 = 0; k3 = 0; k4 = 0;
        bus_start();
        send_byte({a, 1'b0}, k0);
        send_byte(c, k1);
        send_byte(w[7:0], k2);
        if (nbytes > 1) send_byte(w[15:8], k3);
        if (nbytes > 2) send_byte(8'hA5, k4);
        bus_stop();
        observe({27'd0, k4, k3, k2, k1, k0});
    endtask

    task automatic rd_txn(input logic [6:0] a, input logic [7:0] c);
        logic k0, k1, k2;
        logic [7:0] lo, hi;
        bus_start();
        send_byte({a, 1'b0}, k0);
        send_byte(c, k1);
        bus_start();
        send_byte({a, 1'b1}, k2);
        recv_byte(1'b1, lo);
        recv_byte(1'b0, hi);
        bus_stop();
        observe({13'd0, k2, k1, k0, hi, lo});
    endtask

    task automatic drain();
        while (exp_q.size() > 0 || act_q.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int tk;
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check(3, cfg, 16'h0000);          // R3 reset value
        check(9, sda_pull, 1'b0);         // R9 released after reset

        // R1 / R3: strap low, address 0x70, all five acks on a 2-byte write
        expect_item(1, 32'h0000_000F);
        wr_txn(7'h70, 8'hD0, 16'h1234, 2);
        drain();
        check(3, cfg, 16'h1234);

        // R5: configuration readback, no strobe (R8)
        tk = taken_cnt;
        expect_item(5, {13'd0, 3'b111, 16'h1234});
        rd_txn(7'h70, 8'hD0);
        drain();
        check(8, taken_cnt, tk);

        // R6 / R8: three aliased measurement codes
        expect_item(6, {13'd0, 3'b111, 16'h1380});
        rd_txn(7'h70, 8'h8B);
        drain();
        check(8, taken_cnt, tk + 1);
        meas = 16'hF740;
        expect_item(6, {13'd0, 3'b111, 16'hF740});
        rd_txn(7'h70, 8'h8C);
        expect_item(6, {13'd0, 3'b111, 16'hF740});
        rd_txn(7'h70, 8'h96);
        drain();
        check(8, taken_cnt, tk + 3);

        // R7: reserved and unknown codes acked, read all-ones, writes dropped
        expect_item(7, {13'd0, 3'b111, 16'hFFFF});
        rd_txn(7'h70, 8'hD2);
        expect_item(7, {13'd0, 3'b111, 16'hFFFF});
        rd_txn(7'h70, 8'h00);
        expect_item(7, 32'h0000_000F);
        wr_txn(7'h70, 8'hD5, 16'hBEEF, 2);
        expect_item(7, 32'h0000_000F);
        wr_txn(7'h70, 8'h8B, 16'hBEEF, 2);
        drain();
        check(7, cfg, 16'h1234);

        // R4: stop after one data byte discards the write
        expect_item(4, 32'h0000_0007);
        wr_txn(7'h70, 8'hD0, 16'h5555, 1);
        drain();
        check(4, cfg, 16'h1234);

        // R10: third data byte nacked, committed word kept
        expect_item(10, 32'h0000_000F);
        wr_txn(7'h70, 8'hD0, 16'h0F0F, 3);
        drain();
        check(10, cfg, 16'h0F0F);

        // R2: wrong address, full payload, line never pulled
        pull_cnt = 0;
        expect_item(2, 32'h0000_0000);
        wr_txn(7'h71, 8'hD0, 16'h7777, 3);
        drain();
        check(2, pull_cnt, 0);
        check(2, cfg, 16'h0F0F);

        // R1: other strap levels
        strap = 2'b01;
        expect_item(1, 32'h0000_000F);
        wr_txn(7'h72, 8'hD0, 16'h2222, 2);
        expect_item(1, 32'h0000_0000);
        wr_txn(7'h70, 8'hD0, 16'h9999, 2);
        drain();
        check(1, cfg, 16'h2222);
        strap = 2'b10;
        expect_item(1, 32'h0000_000F);
        wr_txn(7'h76, 8'hD0, 16'h3333, 2);
        drain();
        check(1, cfg, 16'h3333);
        strap = 2'b11;
        expect_item(1, 32'h0000_0000);
        wr_txn(7'h70, 8'hD0, 16'h4444, 2);
        expect_item(1, 32'h0000_0000);
        wr_txn(7'h76, 8'hD0, 16'h4444, 2);
        drain();
        check(1, cfg, 16'h3333);

        // R9: no drive change ever seen while SCL was high
        check(9, bad_moves, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule